// File: doc/BRIEF.md
# Dual-Path Registered Inverting Bus Transceiver

This block connects two bidirectional data buses, called A and B, through two storage registers, one for each direction of transfer. The forward path takes A-side data into its register on a rising edge of its own clock, but only while its active-low load strobe is asserted. It then presents the bitwise complement of that stored word to the B side. The B side is driven only while the forward path's active-low output enable is asserted. The reverse path mirrors this exactly, with its own clock, load strobe and output enable. The two paths never exchange state.

On-chip tri-states cannot be synthesized, so each bus appears as three signals: an input vector, an output vector and a drive flag. A wrapper at the pad level builds the real inout from them, releasing the bus whenever the drive flag is low. An active-low asynchronous reset stands in for power-up. It clears both registers and holds both drive flags low for as long as it is asserted.

Each side also has a clash flag. It rises when this block is driving a bus at the same moment as the opposite path is set to load from that bus. Integration logic can use it to spot self-contention.

Top module: `xcvr_reg_inv`

## Requirements
- R1: On a rising edge of a path's clock with that path's load strobe low (0), the path's register takes the value present on its source bus input (A for the forward path, B for the reverse path).
- R2: On a rising edge of a path's clock with that path's load strobe high (1), the path's register keeps its previous value.
- R3: The data output toward the destination bus always equals the bitwise complement of the path's stored word.
- R4: A bus's drive flag is 1 exactly when reset is released and the output enable of the path feeding that bus is low (0). Otherwise the flag is 0, which means high impedance.
- R5: While the reset input is low, both registers are zero and both drive flags are 0, so both data outputs read all ones. The reset acts without waiting for a clock edge.
- R6: One path's clock, load strobe and output enable have no effect on the other path's register, data output or drive flag.
- R7: A side's clash flag is 1 exactly when that side's drive flag is 1 and the path that loads from that side has its load strobe low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset (power-up model) |
| fwd_clk | input | 1 | Clock of the A-to-B register |
| fwd_ld_n | input | 1 | Active-low load strobe of the A-to-B register |
| fwd_oe_n | input | 1 | Active-low output enable onto bus B |
| rev_clk | input | 1 | Clock of the B-to-A register |
| rev_ld_n | input | 1 | Active-low load strobe of the B-to-A register |
| rev_oe_n | input | 1 | Active-low output enable onto bus A |
| a_in | input | W | Value observed on bus A |
| a_out | output | W | Complemented reverse-path word for bus A |
| a_drive | output | 1 | 1 when bus A is driven by this block |
| a_clash | output | 1 | Bus A is driven while the forward path loads from it |
| b_in | input | W | Value observed on bus B |
| b_out | output | W | Complemented forward-path word for bus B |
| b_drive | output | 1 | 1 when bus B is driven by this block |
| b_clash | output | 1 | Bus B is driven while the reverse path loads from it |

## Verification
The bench targets the point where a load strobe goes high between edges. A design that samples the strobe on the wrong polarity, or ignores it, would replace a held word with new bus data. Loads are run on one path while the other is frozen. A design that shares a clock or an enable between the paths would disturb the frozen word or its drive flag. Reset is also asserted in the middle of traffic, between clock edges. A design with a synchronous clear, or one that only gated the drives, would keep stale data, or drive a bus, for part of a cycle. Random output-enable and load patterns also exercise the clash flags. A flag wired to the wrong side would stay silent or fire spuriously.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  localparam int XCVR_W_DEF = 8;
  localparam int XCVR_NPATH = 2;

  // bus may be driven only out of reset with an active-low enable asserted
  function automatic logic drive_ok(input logic rst_n, input logic oe_n);
    return rst_n & ~oe_n;
  endfunction

  // a driven bus that the opposite path is about to sample
  function automatic logic clash_on(input logic drive, input logic ld_n);
    return drive & ~ld_n;
  endfunction

endpackage

// File: rtl/xcvr_path_reg.sv
module xcvr_path_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (!ld_n) q <= d;
  end

endmodule

// File: rtl/xcvr_out_stage.sv
module xcvr_out_stage
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         oe_n,
  input  logic [W-1:0] q,
  output logic [W-1:0] dout,
  output logic         drive
);

  always_comb begin
    dout  = ~q;
    drive = drive_ok(rst_n, oe_n);
  end

endmodule

// File: rtl/xcvr_reg_inv.sv
module xcvr_reg_inv
  import xcvr_pkg::*;
#(
  parameter int W = XCVR_W_DEF
) (
  input  logic         rst_n,
  input  logic         fwd_clk,
  input  logic         fwd_ld_n,
  input  logic         fwd_oe_n,
  input  logic         rev_clk,
  input  logic         rev_ld_n,
  input  logic         rev_oe_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drive,
  output logic         a_clash,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  output logic         b_clash
);

  // index 0 = forward (A to B), index 1 = reverse (B to A)
  logic [XCVR_NPATH-1:0]        clk_v, ld_n_v, oe_n_v, drv_v;
  logic [XCVR_NPATH-1:0][W-1:0] src_v, q_v, out_v;

  assign clk_v  = {rev_clk,  fwd_clk};
  assign ld_n_v = {rev_ld_n, fwd_ld_n};
  assign oe_n_v = {rev_oe_n, fwd_oe_n};
  assign src_v  = {b_in,     a_in};

  for (genvar p = 0; p < XCVR_NPATH; p++) begin : g_path
    xcvr_path_reg #(.W(W)) reg_i (
      .clk   (clk_v[p]),
      .rst_n (rst_n),
      .ld_n  (ld_n_v[p]),
      .d     (src_v[p]),
      .q     (q_v[p])
    );
    xcvr_out_stage #(.W(W)) out_i (
      .rst_n (rst_n),
      .oe_n  (oe_n_v[p]),
      .q     (q_v[p]),
      .dout  (out_v[p]),
      .drive (drv_v[p])
    );
  end

  assign b_out   = out_v[0];
  assign b_drive = drv_v[0];
  assign a_out   = out_v[1];
  assign a_drive = drv_v[1];

  // named events for the checker
  logic fwd_load_ev, rev_load_ev;
  assign fwd_load_ev = rst_n & ~fwd_ld_n;
  assign rev_load_ev = rst_n & ~rev_ld_n;

  assign a_clash = clash_on(a_drive, fwd_ld_n);
  assign b_clash = clash_on(b_drive, rev_ld_n);

endmodule

// File: rtl/xcvr_reg_inv_chk.sv
module xcvr_reg_inv_chk #(
  parameter int W = 8
) (
  input logic         rst_n,
  input logic         fwd_clk,
  input logic         fwd_ld_n,
  input logic         fwd_oe_n,
  input logic         rev_clk,
  input logic         rev_ld_n,
  input logic         rev_oe_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_drive,
  input logic         a_clash,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         b_drive,
  input logic         b_clash,
  input logic         fwd_load_ev,
  input logic         rev_load_ev
);

  AST_FWD_LOAD: assert property (@(posedge fwd_clk) disable iff (!rst_n)
    fwd_load_ev |=> (b_out == ~$past(a_in))); // R1
  AST_REV_LOAD: assert property (@(posedge rev_clk) disable iff (!rst_n)
    rev_load_ev |=> (a_out == ~$past(b_in))); // R1
  AST_FWD_HOLD: assert property (@(posedge fwd_clk) disable iff (!rst_n)
    (rst_n && fwd_ld_n) |=> $stable(b_out)); // R2
  AST_REV_HOLD: assert property (@(posedge rev_clk) disable iff (!rst_n)
    (rst_n && rev_ld_n) |=> $stable(a_out)); // R2
  AST_B_RELEASE: assert property (@(posedge fwd_clk) disable iff (!rst_n)
    fwd_oe_n |-> !b_drive); // R4
  AST_A_RELEASE: assert property (@(posedge rev_clk) disable iff (!rst_n)
    rev_oe_n |-> !a_drive); // R4
  AST_A_CLASH: assert property (@(posedge fwd_clk) disable iff (!rst_n)
    (a_drive && !fwd_ld_n) |-> a_clash); // R7
  AST_B_CLASH: assert property (@(posedge rev_clk) disable iff (!rst_n)
    (b_drive && !rev_ld_n) |-> b_clash); // R7

  always @(posedge fwd_clk) begin
    if (rst_n === 1'b0) begin
      AST_RESET_QUIET: assert (!a_drive && !b_drive && (&a_out) && (&b_out)); // R5
    end
  end

endmodule

bind xcvr_reg_inv xcvr_reg_inv_chk #(.W(W)) chk_i (
  .rst_n(rst_n), .fwd_clk(fwd_clk), .fwd_ld_n(fwd_ld_n), .fwd_oe_n(fwd_oe_n),
  .rev_clk(rev_clk), .rev_ld_n(rev_ld_n), .rev_oe_n(rev_oe_n),
  .a_in(a_in), .a_out(a_out), .a_drive(a_drive), .a_clash(a_clash),
  .b_in(b_in), .b_out(b_out), .b_drive(b_drive), .b_clash(b_clash),
  .fwd_load_ev(fwd_load_ev), .rev_load_ev(rev_load_ev)
);

// File: tb/xcvr_reg_inv_tb.sv
module xcvr_reg_inv_tb_top;

  localparam int W = 8;

  logic         rst_n = 1'b0;
  logic         fwd_clk = 1'b0, rev_clk = 1'b0;
  logic         fwd_ld_n = 1'b1, fwd_oe_n = 1'b1;
  logic         rev_ld_n = 1'b1, rev_oe_n = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_drive, b_drive, a_clash, b_clash;

  int n_vec = 0;
  int n_bad = 0;

  // model state: plain integers, updated once per cycle
  int m_fwd = 0;
  int m_rev = 0;

  xcvr_reg_inv #(.W(W)) dut_i (
    .rst_n(rst_n),
    .fwd_clk(fwd_clk), .fwd_ld_n(fwd_ld_n), .fwd_oe_n(fwd_oe_n),
    .rev_clk(rev_clk), .rev_ld_n(rev_ld_n), .rev_oe_n(rev_oe_n),
    .a_in(a_in), .a_out(a_out), .a_drive(a_drive), .a_clash(a_clash),
    .b_in(b_in), .b_out(b_out), .b_drive(b_drive), .b_clash(b_clash)
  );

  // 50 MHz on both paths; reverse clock lags by 5 ns
  initial forever #10 fwd_clk = ~fwd_clk;
  initial begin #5; forever #10 rev_clk = ~rev_clk; end

  task automatic cmp(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // inputs were set at cycle start; both edges fall inside; check at +18
  task automatic run_cycle(input string req);
    int  ed_a, ed_b;
    int  mask;
    mask = (1 << W) - 1;
    #18;
    if (rst_n !== 1'b1) begin
      m_fwd = 0;
      m_rev = 0;
    end else begin
      if (fwd_ld_n == 1'b0) m_fwd = int'(a_in);
      if (rev_ld_n == 1'b0) m_rev = int'(b_in);
    end
    ed_b = (rst_n === 1'b1 && fwd_oe_n == 1'b0) ? 1 : 0;
    ed_a = (rst_n === 1'b1 && rev_oe_n == 1'b0) ? 1 : 0;
    cmp(req,  "b_out",   int'(b_out),   (~m_fwd) & mask);
    cmp(req,  "a_out",   int'(a_out),   (~m_rev) & mask);
    cmp("R4", "b_drive", int'(b_drive), ed_b);
    cmp("R4", "a_drive", int'(a_drive), ed_a);
    cmp("R7", "a_clash", int'(a_clash), (ed_a == 1 && fwd_ld_n == 1'b0) ? 1 : 0);
    cmp("R7", "b_clash", int'(b_clash), (ed_b == 1 && rev_ld_n == 1'b0) ? 1 : 0);
    #2;
  endtask

  initial begin
    #1;
    // R5: reset state with enables and loads requested
    fwd_oe_n = 1'b0; rev_oe_n = 1'b0; fwd_ld_n = 1'b0; rev_ld_n = 1'b0;
    a_in = 8'h12; b_in = 8'h34;
    repeat (3) run_cycle("R5");
    rst_n = 1'b1;
    // R1 + R3: forward load of 3C gives C3 on B
    fwd_ld_n = 1'b0; rev_ld_n = 1'b1; a_in = 8'h3C;
    run_cycle("R1");
    run_cycle("R3");
    // R2: strobe high, new data ignored
    fwd_ld_n = 1'b1; a_in = 8'hFF;
    repeat (2) run_cycle("R2");
    // R6: reverse loads and toggles while forward is frozen
    rev_ld_n = 1'b0; b_in = 8'h5A; rev_oe_n = 1'b1;
    run_cycle("R6");
    rev_oe_n = 1'b0; b_in = 8'h0F;
    run_cycle("R6");
    // R6: forward changes while reverse is frozen
    rev_ld_n = 1'b1; fwd_ld_n = 1'b0; fwd_oe_n = 1'b1; a_in = 8'h81;
    run_cycle("R6");
    // random traffic
    for (int i = 0; i < 400; i++) begin
      fwd_ld_n = 1'($urandom_range(0, 1));
      rev_ld_n = 1'($urandom_range(0, 1));
      fwd_oe_n = 1'($urandom_range(0, 1));
      rev_oe_n = 1'($urandom_range(0, 1));
      a_in = W'($urandom);
      b_in = W'($urandom);
      run_cycle("R1");
    end
    // R5: reset asserted mid-traffic, between edges
    fwd_ld_n = 1'b1; rev_ld_n = 1'b1; fwd_oe_n = 1'b0; rev_oe_n = 1'b0;
    rst_n = 1'b0;
    run_cycle("R5");
    rst_n = 1'b1;
    run_cycle("R2");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule